// File: doc/BRIEF.md
# Event Integrity Checker

The block inspects every event that arrives on one or more 17-bit input lanes before the event is passed to a downstream processor. Each lane word carries 16 data bits plus one control bit that marks the final word of an event. While an event streams in, the block tracks its position in the frame. It captures the 32-bit front-end chip mask, runs a CRC over each chip's data block, and runs a second CRC over the whole event. It also counts the words.

When the final word arrives, the block compares the transmitted global CRC and the word count against their expected values. It then publishes a status record for that lane and pulses that lane's completion interrupt. The status record has three parts: a compacted 16-bit chip mask, a 16-bit per-chip CRC verdict field, and two error bits. The expected length comes from the configured chip count, samples per chip and gain count, plus fixed header and trailer sizes. Each lane has its own parser and its own interrupt. All lanes share the configuration.

Top module: `evt_integrity_chk`

## Requirements
- R1: Lane word bits 15:0 carry data and bit 16 is set only on the final word of an event. A word is taken only in a cycle where its lane's valid bit is high, and words offered with valid low have no effect.
- R2: An event is laid out as follows:
  - HDR_WORDS header words, whose last two words are the chip mask high half followed by the low half.
  - cfg_chips_i chip blocks, each made of cfg_samples_i×cfg_gains_i data words followed by one check word.
  - TRL_WORDS trailer words, the last of which is the global CRC word carrying bit 16.
  - Configuration is held constant while events flow, and samples and gains are at least 1.
- R3: The compacted mask bit k equals bit 2k OR bit 2k+1 of the 32-bit chip mask (high half = bits 31:16).
- R4: The CRC is CRC-16 with polynomial 0x8005, initial value 0, and no final inversion. It is fed one 16-bit word per step, most significant bit first.
- R5: Bit k of the chip CRC status is set when chip k's check word differs from the CRC of that chip's data words. Bits at index cfg_chips_i and above stay 0.
- R6: Error bit 1 is set when the final word differs from the CRC of all words of the event before it.
- R7: Error bit 0 is set when the number of words in the event, counting the final word, differs from HDR_WORDS + chips×(samples×gains+1) + TRL_WORDS.
- R8: The lane interrupt is high for exactly one cycle, the cycle after the final word is accepted. The status outputs update in that same cycle and then hold their value until the next final word on that lane.
- R9: Each event's status is independent of earlier events. A short event that carries only a final word of value 0 reports mask 0, chip status 0 and error bits 2'b01.
- R10: Lanes are parsed independently and each raises only its own interrupt, including when events overlap in time.
- R11: After reset all interrupts and status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_chips_i | input | 5 | Number of chip blocks per event (0 to 16) |
| cfg_samples_i | input | 6 | Samples per chip per gain |
| cfg_gains_i | input | 2 | Number of gains |
| lane_vld_i | input | LANES | Per-lane word valid |
| lane_word_i | input | 17×LANES | Per-lane words, lane l at bits 17l+16:17l |
| irq_o | output | LANES | Per-lane completion interrupt pulse |
| stat_mask_o | output | 16×LANES | Compacted chip mask per lane |
| stat_crc_o | output | 16×LANES | Per-chip CRC failure bits per lane |
| stat_err_o | output | 2×LANES | Per lane: bit 0 size error, bit 1 global CRC error |

## Verification
Several properties are checked on every cycle by assertions:
- each interrupt matches an accepted final word on the previous cycle;
- status outputs never move without an interrupt;
- no chip CRC bit is reported beyond the configured chip count.

The actual values of the status record can only be shown by scenarios whose expected results the bench builds from the frame layout. Those values are the mask compaction, which block failed, the global CRC verdict and the length verdict. The same holds for behaviour across events and lanes: back-to-back events, gaps with garbage on the bus, overlapping lanes, runt events, and the zero-chip and sixteen-chip boundaries.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DATA_W  = 16;
  localparam int LANE_W  = DATA_W + 1;
  localparam int CHIP_W  = 5;
  localparam int SAMP_W  = 6;
  localparam int GAIN_W  = 2;
  localparam int BLK_W   = SAMP_W + GAIN_W;
  localparam int LEN_W   = 16;
  localparam logic [15:0] CRC_POLY = 16'h8005;

  typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_CHK, ST_TRL} lane_st_e;

  function automatic logic [15:0] crc16_word(logic [15:0] crc, logic [15:0] d);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ d[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [15:0] mask_compact(logic [31:0] m);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = m[2*k] | m[2*k+1];
    return r;
  endfunction
endpackage

// File: rtl/eic_len_calc.sv
module eic_len_calc
  import eic_pkg::*;
#(
  parameter int HDR_WORDS = 2,
  parameter int TRL_WORDS = 2
) (
  input  logic [CHIP_W-1:0] chips_i,
  input  logic [SAMP_W-1:0] samples_i,
  input  logic [GAIN_W-1:0] gains_i,
  output logic [BLK_W-1:0]  blk_len_o,
  output logic [LEN_W-1:0]  exp_len_o
);
  localparam logic [LEN_W-1:0] FIXED = LEN_W'(HDR_WORDS + TRL_WORDS);

  always_comb begin
    blk_len_o = BLK_W'(samples_i) * BLK_W'(gains_i);
    exp_len_o = FIXED + LEN_W'(chips_i) * (LEN_W'(blk_len_o) + LEN_W'(1));
  end
endmodule

// File: rtl/eic_lane.sv
module eic_lane
  import eic_pkg::*;
#(
  parameter int HDR_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHIP_W-1:0] chips_i,
  input  logic [BLK_W-1:0]  blk_len_i,
  input  logic [LEN_W-1:0]  exp_len_i,
  input  logic              vld_i,
  input  logic [LANE_W-1:0] word_i,
  output logic              irq_o,
  output logic [15:0]       mask_o,
  output logic [15:0]       crc_o,
  output logic [1:0]        err_o
);
  localparam int HC_W = $clog2(HDR_WORDS + 1);
  localparam logic [HC_W-1:0] HC_HI = HC_W'(HDR_WORDS - 2);
  localparam logic [HC_W-1:0] HC_LO = HC_W'(HDR_WORDS - 1);

  lane_st_e          st_q;
  logic [HC_W-1:0]   hdr_cnt_q;
  logic [BLK_W-1:0]  sub_cnt_q;
  logic [CHIP_W-1:0] chip_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [15:0]       ccrc_q, gcrc_q, fail_q;
  logic [31:0]       mask_q;

  logic [15:0] d;
  logic        last;
  assign d    = word_i[DATA_W-1:0];
  assign last = vld_i & word_i[DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_HDR;
      hdr_cnt_q <= '0;
      sub_cnt_q <= '0;
      chip_q    <= '0;
      cnt_q     <= '0;
      ccrc_q    <= '0;
      gcrc_q    <= '0;
      fail_q    <= '0;
      mask_q    <= '0;
      irq_o     <= 1'b0;
      mask_o    <= '0;
      crc_o     <= '0;
      err_o     <= '0;
    end else begin
      irq_o <= 1'b0;
      if (last) begin
        irq_o     <= 1'b1;
        mask_o    <= mask_compact(mask_q);
        crc_o     <= fail_q;
        err_o     <= {d != gcrc_q, (cnt_q + LEN_W'(1)) != exp_len_i};
        st_q      <= ST_HDR;
        hdr_cnt_q <= '0;
        sub_cnt_q <= '0;
        chip_q    <= '0;
        cnt_q     <= '0;
        ccrc_q    <= '0;
        gcrc_q    <= '0;
        fail_q    <= '0;
        mask_q    <= '0;
      end else if (vld_i) begin
        cnt_q  <= cnt_q + LEN_W'(1);
        gcrc_q <= crc16_word(gcrc_q, d);
        unique case (st_q)
          ST_HDR: begin
            if (hdr_cnt_q == HC_HI) mask_q[31:16] <= d;
            if (hdr_cnt_q == HC_LO) begin
              mask_q[15:0] <= d;
              st_q         <= (chips_i == '0) ? ST_TRL : ST_DATA;
            end else begin
              hdr_cnt_q <= hdr_cnt_q + HC_W'(1);
            end
          end
          ST_DATA: begin
            ccrc_q <= crc16_word(ccrc_q, d);
            if (sub_cnt_q == blk_len_i - BLK_W'(1)) begin
              sub_cnt_q <= '0;
              st_q      <= ST_CHK;
            end else begin
              sub_cnt_q <= sub_cnt_q + BLK_W'(1);
            end
          end
          ST_CHK: begin
            if (d != ccrc_q) fail_q[chip_q[3:0]] <= 1'b1;
            ccrc_q <= '0;
            chip_q <= chip_q + CHIP_W'(1);
            st_q   <= (chip_q == chips_i - CHIP_W'(1)) ? ST_TRL : ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(vld_i && word_i[DATA_W]));
  // R8
  irq_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && word_i[DATA_W]) |=> irq_o);
  // R8
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> ($stable(mask_o) && $stable(crc_o) && $stable(err_o)));
  // R5
  crc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((32'(crc_o) >> chips_i) == 32'd0));
endmodule

// File: rtl/evt_integrity_chk.sv
module evt_integrity_chk
  import eic_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int HDR_WORDS = 2,
  parameter int TRL_WORDS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CHIP_W-1:0]       cfg_chips_i,
  input  logic [SAMP_W-1:0]       cfg_samples_i,
  input  logic [GAIN_W-1:0]       cfg_gains_i,
  input  logic [LANES-1:0]        lane_vld_i,
  input  logic [LANES*LANE_W-1:0] lane_word_i,
  output logic [LANES-1:0]        irq_o,
  output logic [LANES*16-1:0]     stat_mask_o,
  output logic [LANES*16-1:0]     stat_crc_o,
  output logic [LANES*2-1:0]      stat_err_o
);
  logic [BLK_W-1:0] blk_len;
  logic [LEN_W-1:0] exp_len;

  eic_len_calc #(.HDR_WORDS(HDR_WORDS), .TRL_WORDS(TRL_WORDS)) u_len (
    .chips_i   (cfg_chips_i),
    .samples_i (cfg_samples_i),
    .gains_i   (cfg_gains_i),
    .blk_len_o (blk_len),
    .exp_len_o (exp_len)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    eic_lane #(.HDR_WORDS(HDR_WORDS)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .chips_i   (cfg_chips_i),
      .blk_len_i (blk_len),
      .exp_len_i (exp_len),
      .vld_i     (lane_vld_i[l]),
      .word_i    (lane_word_i[l*LANE_W +: LANE_W]),
      .irq_o     (irq_o[l]),
      .mask_o    (stat_mask_o[l*16 +: 16]),
      .crc_o     (stat_crc_o[l*16 +: 16]),
      .err_o     (stat_err_o[l*2 +: 2])
    );
  end
endmodule

// File: tb/evt_integrity_chk_test.sv
module evt_integrity_chk_test;
  localparam int HDR = 2;
  localparam int TRL = 2;

  typedef struct packed {
    logic [15:0] m;
    logic [15:0] c;
    logic [1:0]  e;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  chips = 5'd4;
  logic [5:0]  samples = 6'd3;
  logic [1:0]  gains = 2'd2;
  logic [1:0]  vld = '0;
  logic [16:0] wd [2];
  logic [1:0]  irq;
  logic [31:0] smask, scrc;
  logic [3:0]  serr;

  int total = 0, bad = 0;
  int sent [2];
  int seen [2];
  exp_t q0[$], q1[$];
  exp_t last_e [2];

  always #4 clk = ~clk;

  evt_integrity_chk #(.LANES(2), .HDR_WORDS(HDR), .TRL_WORDS(TRL)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_chips_i(chips), .cfg_samples_i(samples), .cfg_gains_i(gains),
    .lane_vld_i(vld), .lane_word_i({wd[1], wd[0]}),
    .irq_o(irq), .stat_mask_o(smask), .stat_crc_o(scrc), .stat_err_o(serr)
  );

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [15:0] w);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] != w[i]) r = (r << 1) ^ 16'h8005;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_cmp(logic [31:0] m);
    logic [15:0] r = '0;
    for (int k = 0; k < 16; k++) if (m[2*k +: 2] != 2'b00) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_event(int l, logic [31:0] mask, int bad_chip, bit bad_g,
                            int len_adj, bit gaps, bit runt, int seed);
    logic [15:0] w[$];
    logic [15:0] g, cc, fin;
    exp_t e;
    int nblk;
    e.m = ref_cmp(mask);
    e.c = '0;
    if (runt) begin
      e = '{m: 16'h0, c: 16'h0, e: 2'b01};
      fin = 16'h0;
    end else begin
      nblk = int'(samples) * int'(gains);
      for (int i = 0; i < HDR - 2; i++) w.push_back(16'(seed + i));
      w.push_back(mask[31:16]);
      w.push_back(mask[15:0]);
      for (int c = 0; c < int'(chips); c++) begin
        cc = '0;
        for (int i = 0; i < nblk; i++) begin
          w.push_back(16'(seed * 37 + c * 11 + i * 5 + 3));
          cc = ref_crc(cc, w[w.size()-1]);
        end
        if (c == bad_chip) begin
          cc = cc ^ 16'h0001;
          e.c[c] = 1'b1;
        end
        w.push_back(cc);
      end
      for (int i = 0; i < TRL - 1; i++) w.push_back(16'(seed ^ 16'h5a5a));
      if (len_adj > 0) w.push_back(16'h1234);
      if (len_adj < 0) void'(w.pop_back());
      g = '0;
      foreach (w[i]) g = ref_crc(g, w[i]);
      fin = bad_g ? (g ^ 16'h8000) : g;
      e.e = {bad_g, len_adj != 0};
    end
    if (l == 0) q0.push_back(e); else q1.push_back(e);
    last_e[l] = e;
    sent[l]++;
    foreach (w[i]) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        vld[l] = 1'b0;
        wd[l]  = 17'h1dead;  // R1: garbage with final-marker while invalid
      end
      @(negedge clk);
      vld[l] = 1'b1;
      wd[l]  = {1'b0, w[i]};
    end
    @(negedge clk);
    vld[l] = 1'b1;
    wd[l]  = {1'b1, fin};
    @(negedge clk);
    vld[l] = 1'b0;
    wd[l]  = 17'h0;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 2; l++) begin
        if (irq[l]) begin
          exp_t e;
          seen[l]++;
          if ((l == 0 && q0.size() == 0) || (l == 1 && q1.size() == 0)) begin
            check(1'b0, "R10 unexpected irq", 32'(l), 32'hffff);
          end else begin
            e = (l == 0) ? q0.pop_front() : q1.pop_front();
            check(smask[l*16 +: 16] == e.m, "R3 mask", 32'(smask[l*16 +: 16]), 32'(e.m));
            check(scrc[l*16 +: 16] == e.c, "R5 chip crc", 32'(scrc[l*16 +: 16]), 32'(e.c));
            check(serr[l*2] == e.e[0], "R7 size err", 32'(serr[l*2]), 32'(e.e[0]));
            check(serr[l*2+1] == e.e[1], "R6 gcrc err", 32'(serr[l*2+1]), 32'(e.e[1]));
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    sent = '{0, 0};
    seen = '{0, 0};
    wd[0] = '0; wd[1] = '0;
    repeat (3) @(negedge clk);
    // R11
    check(irq == 2'b00 && smask == '0 && scrc == '0 && serr == '0,
          "R11 reset state", {irq, serr, 26'(smask)}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 2'b00 && smask == '0 && scrc == '0 && serr == '0,
          "R11 after release", {irq, serr, 26'(smask)}, 32'h0);

    // R2 R4 clean event, then R9 back-to-back error and clean
    send_event(0, 32'h8001_0300, -1, 1'b0, 0, 1'b0, 1'b0, 1);
    send_event(0, 32'hffff_0000, 2, 1'b0, 0, 1'b0, 1'b0, 2);
    send_event(0, 32'h0000_000c, -1, 1'b0, 0, 1'b0, 1'b0, 3);
    // R6 R7 on lane 1
    send_event(1, 32'h1234_5678, -1, 1'b1, 0, 1'b0, 1'b0, 4);
    send_event(1, 32'haaaa_5555, -1, 1'b0, 1, 1'b0, 1'b0, 5);
    send_event(0, 32'h0f0f_f0f0, 0, 1'b0, -1, 1'b0, 1'b0, 6);
    // R10 overlapping lanes with R1 gaps
    fork
      send_event(0, 32'hc000_0003, 3, 1'b0, 0, 1'b1, 1'b0, 7);
      send_event(1, 32'h0000_0001, -1, 1'b1, 0, 1'b0, 1'b0, 8);
    join
    // R9 runt event
    send_event(1, 32'h0, -1, 1'b0, 0, 1'b0, 1'b1, 9);
    drain();

    // R8 status holds while idle with garbage on invalid lanes
    wd[0] = 17'h1ffff; wd[1] = 17'h1ffff;
    repeat (10) @(negedge clk);
    check(irq == 2'b00, "R8 no irq while idle", 32'(irq), 32'h0);
    check(smask[15:0] == last_e[0].m && scrc[15:0] == last_e[0].c && serr[1:0] == last_e[0].e,
          "R8 lane0 hold", {smask[15:0], scrc[15:0]}, {last_e[0].m, last_e[0].c});
    check(smask[31:16] == last_e[1].m && scrc[31:16] == last_e[1].c && serr[3:2] == last_e[1].e,
          "R8 lane1 hold", {smask[31:16], scrc[31:16]}, {last_e[1].m, last_e[1].c});
    wd[0] = '0; wd[1] = '0;

    // R5 boundary: sixteen chips, last chip bad
    chips = 5'd16; samples = 6'd1; gains = 2'd1;
    @(negedge clk);
    send_event(0, 32'hffff_ffff, 15, 1'b0, 0, 1'b1, 1'b0, 10);
    send_event(1, 32'h8000_0000, 0, 1'b1, 1, 1'b0, 1'b0, 11);
    drain();

    // R2 zero chips
    chips = 5'd0; samples = 6'd2; gains = 2'd3;
    @(negedge clk);
    send_event(0, 32'h0003_0000, -1, 1'b0, 0, 1'b0, 1'b0, 12);
    send_event(1, 32'h0, -1, 1'b0, -1, 1'b0, 1'b0, 13);
    drain();

    // R8 R10 one irq per event per lane
    check(seen[0] == sent[0], "R8 lane0 irq count", 32'(seen[0]), 32'(sent[0]));
    check(seen[1] == sent[1], "R10 lane1 irq count", 32'(seen[1]), 32'(sent[1]));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule